// File: doc/BRIEF.md
# Four-Mode Serial Port with Address-Frame Filtering

A serial port in the classic microcontroller style, steered by one 8-bit control register. It has four framings. Mode 0 is a synchronous shifter: the TX pin carries the shift clock and the data bits move on the RX line. Mode 1 is an 8-bit asynchronous frame. Modes 2 and 3 add a ninth bit that software supplies on transmit and the hardware captures on receive. Modes 1 and 3 take their 16x bit-rate tick from outside the block. Mode 2 makes its tick from a fixed divide of the system clock.

A multidrop bus needs nodes that only wake up for address frames. The address-match bit gives this. In the 9-bit modes, a frame whose ninth bit is 0 is then dropped and raises no flag. In mode 1 the same bit drops frames that end with a bad stop bit. The hardware sets the transmit and receive flags and only software clears them. They are ORed, under an external enable, onto a single interrupt line. Writing the data buffer starts a transmission. Reading it returns the last byte the receiver accepted.

Control register layout (read and write): [7:6] mode (00 shift, 01 8-bit variable rate, 10 9-bit fixed rate, 11 9-bit variable rate), [5] receive enable, [4] address-match enable, [3] transmit ninth bit, [2] received ninth bit, [1] transmit flag, [0] receive flag.

Top module: `mpser_port`

## Requirements
- R1: After reset the control register reads 0x00, txd is 1, rxd_oe is 0 and irq is 0.
- R2: In mode 1, writing the data buffer sends a start bit (0), then the eight data bits LSB first, then a stop bit (1). Each bit lasts 16 baud_tick pulses. The transmit flag (ctrl bit 1) is 0 during the data bits and 1 once the stop bit has begun.
- R3: In modes 2 and 3, ctrl bit 3 is sent as a ninth bit between the data bits and the stop bit. In mode 2 the bit time is 16*M2_DIV clocks and does not depend on baud_tick.
- R4: In modes 1 to 3 with receive enable set, a frame arriving on rxd_in is sampled with a majority of three samples at the bit middle. Its byte appears in the data buffer. The receive flag (ctrl bit 0) rises during the stop bit, once the stop bit's middle has been sampled.
- R5: In modes 2 and 3 an accepted frame stores its ninth bit in ctrl bit 2. In mode 1 that bit takes the received stop bit.
- R6: In mode 1 with address-match set, a frame whose stop bit is 0 leaves the buffer, ctrl bit 2 and the receive flag unchanged. With address-match clear, the same frame is accepted.
- R7: In modes 2 and 3 with address-match set, only frames whose ninth bit is 1 are accepted. With it clear, the ninth bit does not affect acceptance.
- R8: With receive enable clear, no frame is received: the flag and the buffer stay unchanged.
- R9: A low pulse on rxd_in that is gone before the start bit's middle samples is rejected. A frame that follows it is still received correctly.
- R10: The flags are set only by hardware. Writing 1 to a flag bit leaves it as it was, and writing 0 clears it. irq is irq_en AND (transmit flag OR receive flag).
- R11: In mode 0 a buffer write shifts the byte out on rxd_out LSB first, with rxd_oe high, while txd carries a shift clock of 2*M0_DIV clocks per bit. Each bit is valid at the rising clock edge. The transmit flag is 0 at the eighth rising edge and 1 after the eighth bit ends.
- R12: In mode 0 with receive enable set and the receive flag clear, the block clocks in eight bits from rxd_in, LSB first, at the rising edges of txd. It then loads the buffer and sets the receive flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 data buffer |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read source: 0 control, 1 receive buffer |
| rd_data | output | 8 | Read data (combinational) |
| baud_tick | input | 1 | 16x bit-rate tick for modes 1 and 3 |
| irq_en | input | 1 | Interrupt enable |
| rxd_in | input | 1 | Serial input (asynchronous data, or mode 0 data) |
| txd | output | 1 | Asynchronous serial output, or mode 0 shift clock |
| rxd_out | output | 1 | Mode 0 transmit data |
| rxd_oe | output | 1 | Output enable for rxd_out |
| irq | output | 1 | Combined interrupt |

## Verification
The transmit line changes on the clock edge after the buffer write and then every 16 ticks. The bench therefore waits for the falling start edge and samples each bit at its middle. The receive flag shows up about nine or ten ticks into the stop bit, once the input synchronizer and the tick alignment are counted. The bench checks that it is still low six ticks into the stop bit and high thirteen ticks in, so the checks stay clear of that jitter. In mode 0 the bench follows the shift clock on txd itself: it samples rxd_out, or changes rxd_in, at the sample after each observed rising edge. The flags are read a few clocks after the eighth edge, which covers the registered done pulse.

// File: rtl/mpser_pkg.sv
package mpser_pkg;
   typedef enum logic [1:0] {
      MD_SHIFT  = 2'b00,
      MD_UART8  = 2'b01,
      MD_UART9F = 2'b10,
      MD_UART9V = 2'b11
   } sp_mode_e;

   typedef struct packed {
      sp_mode_e mode;
      logic     ren;
      logic     mpe;
      logic     tx9;
      logic     rx9;
      logic     txf;
      logic     rxf;
   } sp_ctrl_t;
endpackage

// File: rtl/mpser_sync.sv
module mpser_sync #(
   parameter int DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tx_go,
   input  logic       rx_go,
   input  logic [7:0] txdata,
   input  logic       rxd,
   output logic       sclk,
   output logic       dout,
   output logic       doe,
   output logic       busy,
   output logic       tx_done,
   output logic       rx_done,
   output logic [7:0] rdata
);
   localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

   logic [7:0]    sh;
   logic [3:0]    ph;
   logic [DW-1:0] dcnt;
   logic          dir_tx;
   logic          step;

   assign step = (dcnt == DW'(DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh      <= '0;
         ph      <= '0;
         dcnt    <= '0;
         dir_tx  <= 1'b0;
         busy    <= 1'b0;
         tx_done <= 1'b0;
         rx_done <= 1'b0;
      end else begin
         tx_done <= 1'b0;
         rx_done <= 1'b0;
         if (!busy) begin
            if (tx_go) begin
               busy   <= 1'b1;
               dir_tx <= 1'b1;
               sh     <= txdata;
               ph     <= '0;
               dcnt   <= '0;
            end else if (rx_go) begin
               busy   <= 1'b1;
               dir_tx <= 1'b0;
               ph     <= '0;
               dcnt   <= '0;
            end
         end else if (step) begin
            dcnt <= '0;
            ph   <= ph + 4'd1;
            if (!ph[0]) begin
               if (!dir_tx) sh <= {rxd, sh[7:1]};
            end else begin
               if (dir_tx) sh <= {1'b0, sh[7:1]};
               if (ph == 4'd15) begin
                  busy    <= 1'b0;
                  tx_done <= dir_tx;
                  rx_done <= !dir_tx;
               end
            end
         end else begin
            dcnt <= dcnt + 1'b1;
         end
      end
   end

   assign sclk  = !busy | ph[0];
   assign dout  = sh[0];
   assign doe   = busy & dir_tx;
   assign rdata = sh;

   p_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ph == 4'd15 && step) |=> !busy);
endmodule

// File: rtl/mpser_atx.sv
module mpser_atx #(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       start,
   input  logic       nine,
   input  logic       bit9,
   input  logic [7:0] data,
   output logic       txd,
   output logic       busy,
   output logic       stop_pulse
);
   localparam int TW = $clog2(OVS);

   logic [10:0]   sreg;
   logic [3:0]    bitn;
   logic [3:0]    stop_idx;
   logic [TW-1:0] tcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg       <= '1;
         bitn       <= '0;
         stop_idx   <= 4'd9;
         tcnt       <= '0;
         busy       <= 1'b0;
         stop_pulse <= 1'b0;
      end else begin
         stop_pulse <= 1'b0;
         if (start && !busy) begin
            busy     <= 1'b1;
            sreg     <= nine ? {1'b1, bit9, data, 1'b0} : {2'b11, data, 1'b0};
            stop_idx <= nine ? 4'd10 : 4'd9;
            bitn     <= '0;
            tcnt     <= '0;
         end else if (busy && tick) begin
            if (tcnt == TW'(OVS - 1)) begin
               tcnt <= '0;
               if (bitn == stop_idx) begin
                  busy <= 1'b0;
               end else begin
                  sreg <= {1'b1, sreg[10:1]};
                  bitn <= bitn + 4'd1;
                  if (bitn + 4'd1 == stop_idx) stop_pulse <= 1'b1;
               end
            end else begin
               tcnt <= tcnt + 1'b1;
            end
         end
      end
   end

   assign txd = busy ? sreg[0] : 1'b1;

   p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !txd));
endmodule

// File: rtl/mpser_arx.sv
module mpser_arx #(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       en,
   input  logic       nine,
   input  logic       rxd,
   output logic       busy,
   output logic       done,
   output logic [7:0] data,
   output logic       bit9,
   output logic       stopb
);
   localparam int TW = $clog2(OVS);
   localparam int S0 = OVS / 2 - 1;
   localparam int S2 = OVS / 2 + 1;

   logic [TW-1:0] tcnt;
   logic [3:0]    bitn;
   logic [3:0]    stop_idx;
   logic [1:0]    ones;
   logic [8:0]    sh;
   logic          in_win;
   logic          bitval;

   assign in_win = (tcnt >= TW'(S0)) && (tcnt <= TW'(S2));
   assign bitval = ((ones + {1'b0, rxd}) >= 2'd2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tcnt     <= '0;
         bitn     <= '0;
         stop_idx <= 4'd9;
         ones     <= '0;
         sh       <= '0;
         busy     <= 1'b0;
         done     <= 1'b0;
         stopb    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            if (!busy) begin
               if (en && !rxd) begin
                  busy     <= 1'b1;
                  tcnt     <= '0;
                  bitn     <= '0;
                  ones     <= '0;
                  stop_idx <= nine ? 4'd10 : 4'd9;
               end
            end else begin
               if (in_win && tcnt != TW'(S2)) ones <= ones + {1'b0, rxd};
               if (tcnt == TW'(S2)) begin
                  if (bitn == 4'd0) begin
                     if (bitval) busy <= 1'b0;
                  end else if (bitn == stop_idx) begin
                     busy  <= 1'b0;
                     done  <= 1'b1;
                     stopb <= bitval;
                  end else begin
                     sh <= {bitval, sh[8:1]};
                  end
               end
               if (tcnt == TW'(OVS - 1)) begin
                  tcnt <= '0;
                  bitn <= bitn + 4'd1;
                  ones <= '0;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
         end
      end
   end

   assign data = nine ? sh[7:0] : sh[8:1];
   assign bit9 = sh[8];

   p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !busy) |=> !busy);
endmodule

// File: rtl/mpser_port.sv
module mpser_port
   import mpser_pkg::*;
#(
   parameter int OVS    = 16,
   parameter int M0_DIV = 2,
   parameter int M2_DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic       wr_sel,
   input  logic [7:0] wr_data,
   input  logic       rd_sel,
   output logic [7:0] rd_data,
   input  logic       baud_tick,
   input  logic       irq_en,
   input  logic       rxd_in,
   output logic       txd,
   output logic       rxd_out,
   output logic       rxd_oe,
   output logic       irq
);
   generate
      if (OVS < 8 || (OVS % 2) != 0 || OVS > 64) begin : g_bad_ovs
         initial $error("OVS must be even and within 8..64");
      end
      if (M0_DIV < 1 || M2_DIV < 1) begin : g_bad_div
         initial $error("divider parameters must be at least 1");
      end
   endgenerate

   sp_ctrl_t   ctl;
   logic [7:0] rbuf;
   logic       rx_m, rx_s;
   logic       fix_tick, tick;
   logic       mode0, data_wr;
   logic       s_tx_go, s_rx_go, s_busy, s_tx_done, s_rx_done, s_sclk;
   logic [7:0] s_rdata;
   logic       a_txd, a_tx_busy, a_stop_start;
   logic       a_rx_busy, a_done, a_b9, a_stop;
   logic [7:0] a_data;
   logic       accept, set_tx, set_rx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_m <= 1'b1;
         rx_s <= 1'b1;
      end else begin
         rx_m <= rxd_in;
         rx_s <= rx_m;
      end
   end

   generate
      if (M2_DIV == 1) begin : g_fix_every
         assign fix_tick = 1'b1;
      end else begin : g_fix_div
         localparam int FW = $clog2(M2_DIV);
         logic [FW-1:0] fcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       fcnt <= '0;
            else if (fcnt == FW'(M2_DIV - 1)) fcnt <= '0;
            else                              fcnt <= fcnt + 1'b1;
         end
         assign fix_tick = (fcnt == FW'(M2_DIV - 1));
      end
   endgenerate

   assign tick    = (ctl.mode == MD_UART9F) ? fix_tick : baud_tick;
   assign mode0   = (ctl.mode == MD_SHIFT);
   assign data_wr = wr_en && wr_sel;
   assign s_tx_go = data_wr && mode0;
   assign s_rx_go = mode0 && ctl.ren && !ctl.rxf && !s_rx_done && !data_wr;

   mpser_sync #(.DIV(M0_DIV)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .tx_go   (s_tx_go),
      .rx_go   (s_rx_go),
      .txdata  (wr_data),
      .rxd     (rx_s),
      .sclk    (s_sclk),
      .dout    (rxd_out),
      .doe     (rxd_oe),
      .busy    (s_busy),
      .tx_done (s_tx_done),
      .rx_done (s_rx_done),
      .rdata   (s_rdata)
   );

   mpser_atx #(.OVS(OVS)) u_atx (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .start      (data_wr && !mode0),
      .nine       (ctl.mode[1]),
      .bit9       (ctl.tx9),
      .data       (wr_data),
      .txd        (a_txd),
      .busy       (a_tx_busy),
      .stop_pulse (a_stop_start)
   );

   mpser_arx #(.OVS(OVS)) u_arx (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .en    (ctl.ren && !mode0),
      .nine  (ctl.mode[1]),
      .rxd   (rx_s),
      .busy  (a_rx_busy),
      .done  (a_done),
      .data  (a_data),
      .bit9  (a_b9),
      .stopb (a_stop)
   );

   assign accept = a_done && ((ctl.mode == MD_UART8) ? (!ctl.mpe || a_stop)
                                                     : (!ctl.mpe || a_b9));
   assign set_tx = a_stop_start | s_tx_done;
   assign set_rx = accept | s_rx_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl  <= '0;
         rbuf <= '0;
      end else begin
         if (wr_en && !wr_sel) begin
            ctl.mode <= sp_mode_e'(wr_data[7:6]);
            ctl.ren  <= wr_data[5];
            ctl.mpe  <= wr_data[4];
            ctl.tx9  <= wr_data[3];
            ctl.rx9  <= wr_data[2];
            ctl.txf  <= ctl.txf & wr_data[1];
            ctl.rxf  <= ctl.rxf & wr_data[0];
         end
         if (set_tx) ctl.txf <= 1'b1;
         if (s_rx_done) begin
            rbuf    <= s_rdata;
            ctl.rxf <= 1'b1;
         end else if (accept) begin
            rbuf    <= a_data;
            ctl.rx9 <= (ctl.mode == MD_UART8) ? a_stop : a_b9;
            ctl.rxf <= 1'b1;
         end
      end
   end

   assign txd     = mode0 ? s_sclk : a_txd;
   assign irq     = irq_en & (ctl.txf | ctl.rxf);
   assign rd_data = rd_sel ? rbuf : ctl;

   p_txf_hw_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl.txf && !set_tx) |=> !ctl.txf);
   p_rxf_hw_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl.rxf && !set_rx) |=> !ctl.rxf);
   p_filter_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (a_done && ctl.mode[1] && ctl.mpe && !a_b9 && !s_rx_done) |=> $stable(rbuf));
   p_oe_mode0_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rxd_oe |-> mode0);
   p_quiet_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_tx_busy && !mode0) |-> txd);
endmodule

// File: tb/mpser_port_bench.sv
module mpser_port_bench;
   localparam int OVS = 16;
   localparam int M0  = 2;
   localparam int M2  = 2;
   localparam int BT  = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       baud_tick = 1'b0, irq_en = 1'b0, rxd_in = 1'b1;
   logic       txd, rxd_out, rxd_oe, irq;
   int         total = 0, bad = 0, bt = 0;
   logic       finished = 1'b0;

   always #4 clk = ~clk;

   mpser_port #(.OVS(OVS), .M0_DIV(M0), .M2_DIV(M2)) u_mpser_port (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .baud_tick(baud_tick), .irq_en(irq_en),
      .rxd_in(rxd_in), .txd(txd), .rxd_out(rxd_out), .rxd_oe(rxd_oe), .irq(irq)
   );

   initial begin
      forever begin
         @(negedge clk);
         bt = (bt == BT - 1) ? 0 : bt + 1;
         baud_tick = (bt == 0);
      end
   end

   task automatic check(input logic ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic sel, output logic [7:0] v);
      rd_sel = sel;
      #1 v = rd_data;
   endtask

   function automatic logic [7:0] cb(input logic [1:0] md, input logic ren,
                                     input logic mpe, input logic t9);
      return {md, ren, mpe, t9, 3'b000};
   endfunction

   task automatic tx_async(input logic [1:0] md, input logic t9, input logic [7:0] d,
                           input int T, input string tag);
      logic [7:0] v;
      int n;
      wr(1'b0, cb(md, 1'b0, 1'b0, t9));
      wr(1'b1, d);
      n = 0;
      while (txd && n < 100) begin @(negedge clk); n++; end
      repeat (8 * T) @(negedge clk);
      check(txd == 1'b0, {tag, " start bit"}, txd, 0);
      for (int i = 0; i < 8; i++) begin
         repeat (16 * T) @(negedge clk);
         check(txd == d[i], {tag, " data bit"}, txd, d[i]);
      end
      if (md[1]) begin
         repeat (16 * T) @(negedge clk);
         check(txd == t9, {tag, " ninth bit"}, txd, t9);
      end
      rd(1'b0, v);
      check(v[1] == 1'b0, {tag, " txf before stop"}, v[1], 0);
      repeat (16 * T) @(negedge clk);
      check(txd == 1'b1, {tag, " stop bit"}, txd, 1);
      rd(1'b0, v);
      check(v[1] == 1'b1, {tag, " txf in stop"}, v[1], 1);
      repeat (10 * T) @(negedge clk);
   endtask

   task automatic rx_frame(input logic [1:0] md, input logic ren, input logic mpe,
                           input logic [7:0] d, input logic b9, input logic stopv,
                           input int T, input logic acc, input string tag);
      logic [7:0] old, v;
      wr(1'b0, cb(md, ren, mpe, 1'b0));
      rd(1'b1, old);
      rxd_in = 1'b0;
      repeat (16 * T) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rxd_in = d[i];
         repeat (16 * T) @(negedge clk);
      end
      if (md[1]) begin
         rxd_in = b9;
         repeat (16 * T) @(negedge clk);
      end
      rxd_in = stopv;
      repeat (6 * T) @(negedge clk);
      if (acc) begin
         rd(1'b0, v);
         check(v[0] == 1'b0, {tag, " rxf early in stop"}, v[0], 0);
      end
      repeat (7 * T) @(negedge clk);
      if (acc) begin
         rd(1'b0, v);
         check(v[0] == 1'b1, {tag, " rxf after stop sample"}, v[0], 1);
      end
      repeat (3 * T) @(negedge clk);
      rxd_in = 1'b1;
      repeat (24 * T) @(negedge clk);
      rd(1'b0, v);
      check(v[0] == acc, {tag, " rxf final"}, v[0], acc);
      if (acc)
         check(v[2] == (md == 2'b01 ? stopv : b9), {tag, " rx9"}, v[2],
               (md == 2'b01 ? stopv : b9));
      rd(1'b1, v);
      check(v == (acc ? d : old), {tag, " buffer"}, v, (acc ? d : old));
   endtask

   task automatic tx_sync(input logic [7:0] d);
      logic [7:0] got, v;
      logic prev;
      int k, n;
      wr(1'b0, cb(2'b00, 1'b0, 1'b0, 1'b0));
      wr(1'b1, d);
      got = '0; k = 0; n = 0; prev = txd;
      while (k < 8 && n < 16 * M0 + 20) begin
         @(negedge clk); n++;
         if (!prev && txd) begin
            got[k] = rxd_out;
            check(rxd_oe == 1'b1, "R11 oe during shift", rxd_oe, 1);
            if (k == 7) begin
               rd(1'b0, v);
               check(v[1] == 1'b0, "R11 txf at eighth edge", v[1], 0);
            end
            k++;
         end
         prev = txd;
      end
      repeat (4) @(negedge clk);
      check(got == d, "R11 shifted byte", got, d);
      rd(1'b0, v);
      check(v[1] == 1'b1, "R11 txf after byte", v[1], 1);
      check(rxd_oe == 1'b0, "R11 oe released", rxd_oe, 0);
   endtask

   task automatic rx_sync(input logic [7:0] d);
      logic [7:0] v;
      logic prev;
      int k, n;
      rxd_in = d[0];
      wr(1'b0, cb(2'b00, 1'b1, 1'b0, 1'b0));
      k = 0; n = 0; prev = 1'b1;
      while (k < 8 && n < 16 * M0 + 20) begin
         @(negedge clk); n++;
         if (!prev && txd) begin
            k++;
            if (k < 8) rxd_in = d[k];
         end
         prev = txd;
      end
      repeat (4) @(negedge clk);
      rd(1'b0, v);
      check(v[0] == 1'b1, "R12 rxf after byte", v[0], 1);
      rd(1'b1, v);
      check(v == d, "R12 received byte", v, d);
      wr(1'b0, cb(2'b00, 1'b0, 1'b0, 1'b0));
      rxd_in = 1'b1;
      repeat (4 * M0) @(negedge clk);
   endtask

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rd(1'b0, v);
      check(v == 8'h00, "R1 ctrl reset", v, 0);
      check(txd == 1'b1, "R1 txd idle", txd, 1);
      check(rxd_oe == 1'b0, "R1 oe idle", rxd_oe, 0);
      check(irq == 1'b0, "R1 irq idle", irq, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < 6; i++) tx_async(2'b01, 1'b0, 8'((i * 73 + 1) & 255), BT, "R2");
      tx_async(2'b01, 1'b0, 8'h00, BT, "R2");
      tx_async(2'b01, 1'b0, 8'hFF, BT, "R2");
      tx_async(2'b11, 1'b0, 8'hA5, BT, "R3 mode3");
      tx_async(2'b11, 1'b1, 8'h5A, BT, "R3 mode3");
      tx_async(2'b10, 1'b1, 8'hC3, M2, "R3 mode2");
      tx_async(2'b10, 1'b0, 8'h3C, M2, "R3 mode2");

      // R10: flags software-clear only, irq combination
      rd(1'b0, v);
      check(v[1] == 1'b1, "R10 txf held", v[1], 1);
      check(irq == 1'b0, "R10 irq masked", irq, 0);
      irq_en = 1'b1;
      #1 check(irq == 1'b1, "R10 irq raised", irq, 1);
      wr(1'b0, cb(2'b01, 1'b0, 1'b0, 1'b0) | 8'h02);
      rd(1'b0, v);
      check(v[1] == 1'b1, "R10 write 1 keeps txf", v[1], 1);
      wr(1'b0, cb(2'b01, 1'b0, 1'b0, 1'b0));
      rd(1'b0, v);
      check(v[1] == 1'b0, "R10 write 0 clears txf", v[1], 0);
      check(irq == 1'b0, "R10 irq after clear", irq, 0);
      wr(1'b0, cb(2'b01, 1'b0, 1'b0, 1'b0) | 8'h03);
      rd(1'b0, v);
      check(v[1:0] == 2'b00, "R10 write 1 cannot set", v[1:0], 0);
      irq_en = 1'b0;

      for (int i = 0; i < 5; i++)
         rx_frame(2'b01, 1'b1, 1'b0, 8'((i * 91 + 7) & 255), 1'b0, 1'b1, BT, 1'b1, "R4 R5 mode1");
      rx_frame(2'b01, 1'b1, 1'b0, 8'h96, 1'b0, 1'b0, BT, 1'b1, "R6 stop0 mpe0");
      rx_frame(2'b01, 1'b1, 1'b1, 8'h69, 1'b0, 1'b0, BT, 1'b0, "R6 stop0 mpe1");
      rx_frame(2'b01, 1'b1, 1'b1, 8'h69, 1'b0, 1'b1, BT, 1'b1, "R6 stop1 mpe1");
      rx_frame(2'b11, 1'b1, 1'b0, 8'h12, 1'b0, 1'b1, BT, 1'b1, "R5 R7 mode3 b9=0");
      rx_frame(2'b11, 1'b1, 1'b0, 8'h34, 1'b1, 1'b1, BT, 1'b1, "R5 R7 mode3 b9=1");
      rx_frame(2'b11, 1'b1, 1'b1, 8'h56, 1'b0, 1'b1, BT, 1'b0, "R7 mode3 mpe b9=0");
      rx_frame(2'b11, 1'b1, 1'b1, 8'h78, 1'b1, 1'b1, BT, 1'b1, "R7 mode3 mpe b9=1");
      rx_frame(2'b10, 1'b1, 1'b1, 8'h9A, 1'b0, 1'b1, M2, 1'b0, "R7 mode2 mpe b9=0");
      rx_frame(2'b10, 1'b1, 1'b0, 8'hBC, 1'b1, 1'b1, M2, 1'b1, "R5 mode2");
      rx_frame(2'b01, 1'b0, 1'b0, 8'hE1, 1'b0, 1'b1, BT, 1'b0, "R8 ren off");
      rx_frame(2'b11, 1'b0, 1'b0, 8'h1E, 1'b1, 1'b1, BT, 1'b0, "R8 ren off mode3");

      // R9: short low pulse rejected
      wr(1'b0, cb(2'b01, 1'b1, 1'b0, 1'b0));
      rxd_in = 1'b0;
      repeat (3 * BT) @(negedge clk);
      rxd_in = 1'b1;
      repeat (40 * BT) @(negedge clk);
      rd(1'b0, v);
      check(v[0] == 1'b0, "R9 glitch ignored", v[0], 0);
      rx_frame(2'b01, 1'b1, 1'b0, 8'h4D, 1'b0, 1'b1, BT, 1'b1, "R9 frame after glitch");

      tx_sync(8'hA5);
      tx_sync(8'h01);
      tx_sync(8'h80);
      tx_sync(8'h3E);
      rx_sync(8'hC6);
      rx_sync(8'h01);
      rx_sync(8'h7F);

      $display("  test done: total=%0d bad=%0d", total, bad);
      finished = 1'b1;
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule